// File: doc/BRIEF.md
# Reset Pin Glitch Filter

This block decides when the active-low external reset pin is accepted as a reset request. The pin arrives already synchronised to the bus clock. Before it reaches the reset sequencer it passes through one of two level filters, or through no filter at all.

The first filter counts bus-clock enable ticks, and its length is programmable from 1 to 32 ticks. The second filter counts ticks of a slow low-power oscillator and needs a fixed 3 ticks. In run and wait modes a 2-bit select chooses the filter. In stop mode a 1-bit select decides between the low-power filter and no filtering. In low-leakage stop the low-power filter is held cleared and the pin passes straight through.

Two byte-wide registers hold the configuration. Only chip power-on clears them; a warm reset clears the filters but keeps the settings. A small write and read port gives access to both registers.

Top module: `pin_reset_filter`

## Requirements
- R1: After chip power-on the control register (offset 4) and the width register (offset 5) read 0x00, and `rst_req` is low while `pin_n` is high.
- R2: The control register at offset 4 holds the run/wait select in bits 1:0 and the stop select in bit 2. The width register at offset 5 holds the width in bits 4:0. Reserved bits read 0 and any other offset reads 0x00, so writing 0xFF gives 0x07 at offset 4 and 0x1F at offset 5.
- R3: In run mode (`mode` = 00) with run/wait select 00 (disabled) or 11 (reserved), `rst_req` equals the inverse of `pin_n` in the same cycle.
- R4: In run mode with run/wait select 01, `rst_req` takes the new pin level only after the pin has held that level for width+1 consecutive bus ticks. The output changes at the clock edge that counts the last tick. This holds for widths 0, 4 and 31.
- R5: If the pin returns to the accepted level before the count is complete, the count restarts from zero.
- R6: Cycles in which `bus_tick` is low do not advance the bus-clock filter.
- R7: In run mode with run/wait select 10, `rst_req` changes after the pin has held the new level for 3 consecutive `lpo_tick` pulses. Bus ticks have no effect in this setting.
- R8: In stop mode (`mode` = 01), stop select 0 makes `rst_req` follow the pin at once. Stop select 1 uses the low-power filter. The bus-clock filter is held cleared in stop mode, so bus ticks never assert `rst_req` there.
- R9: In low-leakage stop (`mode` = 10 or 11) the low-power filter is held cleared and `rst_req` equals the inverse of `pin_n` in the same cycle.
- R10: A warm reset (`warm_rst_n` low) leaves both registers unchanged. Chip power-on (`por_n` low) returns both registers to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Chip power-on reset, active low; clears configuration and filters |
| warm_rst_n | input | 1 | Any other reset, active low; clears filters only |
| pin_n | input | 1 | Synchronised external reset pin, active low |
| bus_tick | input | 1 | Bus-clock filter enable tick |
| lpo_tick | input | 1 | Low-power oscillator enable tick, one bus cycle wide |
| mode | input | 2 | 00 run/wait, 01 stop, 10/11 low-leakage stop |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 8 | Register read data (combinational) |
| rst_req | output | 1 | Filtered pin reset request, active high |

## Verification
The assertions assume that `pin_n`, `mode` and the tick inputs are synchronous to `clk` and change only between edges. They also assume that `lpo_tick` is a single-cycle pulse. The stimulus drives every input one time unit after a rising edge and pulses `lpo_tick` for exactly one cycle, with idle cycles between pulses. Mode and configuration changes are made only while the pin sits at its accepted level, so the assertion that a filtered level changes only toward the sampled pin is never disturbed by a half-finished count.

// File: rtl/pin_filt_pkg.sv
package pin_filt_pkg;
   localparam logic [1:0] MODE_RUN  = 2'b00;
   localparam logic [1:0] MODE_STOP = 2'b01;

   localparam logic [1:0] RW_OFF = 2'b00;
   localparam logic [1:0] RW_BUS = 2'b01;
   localparam logic [1:0] RW_LPO = 2'b10;

   typedef enum logic [1:0] {
      SRC_BYPASS = 2'b00,
      SRC_BUS    = 2'b01,
      SRC_LPO    = 2'b10
   } filt_src_e;
endpackage

// File: rtl/pin_filt_cfg.sv
module pin_filt_cfg #(
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 8,
   parameter int WIDTH_W   = 5,
   parameter int CTRL_OFS  = 4,
   parameter int WIDTH_OFS = 5
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   output logic [1:0]         rw_sel,
   output logic               stop_sel,
   output logic [WIDTH_W-1:0] width
);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] A_WIDTH = ADDR_W'(WIDTH_OFS);

   logic unused_wr_hi;
   assign unused_wr_hi = ^wr_data[DATA_W-1:WIDTH_W];

   // configuration is cleared by power-on only
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         rw_sel   <= '0;
         stop_sel <= 1'b0;
         width    <= '0;
      end else if (wr_en) begin
         if (wr_addr == A_CTRL) begin
            rw_sel   <= wr_data[1:0];
            stop_sel <= wr_data[2];
         end
         if (wr_addr == A_WIDTH) begin
            width <= wr_data[WIDTH_W-1:0];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_CTRL) begin
         rd_data[2:0] = {stop_sel, rw_sel};
      end else if (rd_addr == A_WIDTH) begin
         rd_data[WIDTH_W-1:0] = width;
      end
   end

   // R10: settings move only on a write
   assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
      !wr_en |=> $stable({rw_sel, stop_sel, width}));

   // R2: reserved control bits never read back as one
   assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!por_n)
      (rd_addr == A_CTRL) |-> (rd_data[DATA_W-1:3] == '0));
endmodule

// File: rtl/pin_filt_stage.sv
module pin_filt_stage #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   input  logic             din,
   output logic             dout
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         dout <= 1'b1;
      end else if (clr || (din == dout)) begin
         cnt  <= '0;
         dout <= din;
      end else if (tick) begin
         if (cnt >= limit) begin
            cnt  <= '0;
            dout <= din;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R6: without a tick or a clear the accepted level holds
   assert_no_tick_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(dout));

   // R4: a new accepted level is always the level the pin had
   assert_moves_to_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout) |-> (dout == $past(din)));
endmodule

// File: rtl/pin_reset_filter.sv
module pin_reset_filter
   import pin_filt_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 8,
   parameter int WIDTH_W   = 5,
   parameter int LPO_TICKS = 3,
   parameter int CTRL_OFS  = 4,
   parameter int WIDTH_OFS = 5
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              warm_rst_n,
   input  logic              pin_n,
   input  logic              bus_tick,
   input  logic              lpo_tick,
   input  logic [1:0]        mode,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rst_req
);
   localparam int LPO_CW = (LPO_TICKS > 1) ? $clog2(LPO_TICKS) : 1;
   localparam logic [LPO_CW-1:0] LPO_LIMIT = LPO_CW'(LPO_TICKS - 1);

   if (DATA_W < WIDTH_W || DATA_W < 3) begin : g_bad_data_w
      $error("pin_reset_filter: DATA_W too narrow for its fields");
   end
   if (LPO_TICKS < 1) begin : g_bad_lpo
      $error("pin_reset_filter: LPO_TICKS must be at least 1");
   end
   if (CTRL_OFS == WIDTH_OFS || CTRL_OFS >= (1 << ADDR_W) || WIDTH_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
      $error("pin_reset_filter: register offsets invalid");
   end

   logic [1:0]         rw_sel;
   logic               stop_sel;
   logic [WIDTH_W-1:0] width;
   filt_src_e          src;
   logic               flt_rst_n;
   logic               bus_lvl, lpo_lvl;

   pin_filt_cfg #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIDTH_W(WIDTH_W),
      .CTRL_OFS(CTRL_OFS), .WIDTH_OFS(WIDTH_OFS)
   ) i_cfg (
      .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .rw_sel(rw_sel), .stop_sel(stop_sel), .width(width)
   );

   always_comb begin
      src = SRC_BYPASS;
      if (mode == MODE_RUN) begin
         if (rw_sel == RW_BUS)      src = SRC_BUS;
         else if (rw_sel == RW_LPO) src = SRC_LPO;
      end else if (mode == MODE_STOP) begin
         if (stop_sel) src = SRC_LPO;
      end
   end

   assign flt_rst_n = por_n & warm_rst_n;

   pin_filt_stage #(.CNT_W(WIDTH_W)) i_bus_flt (
      .clk(clk), .rst_n(flt_rst_n), .clr(src != SRC_BUS), .tick(bus_tick),
      .limit(width), .din(pin_n), .dout(bus_lvl)
   );

   pin_filt_stage #(.CNT_W(LPO_CW)) i_lpo_flt (
      .clk(clk), .rst_n(flt_rst_n), .clr(src != SRC_LPO), .tick(lpo_tick),
      .limit(LPO_LIMIT), .din(pin_n), .dout(lpo_lvl)
   );

   always_comb begin
      case (src)
         SRC_BUS: rst_req = ~bus_lvl;
         SRC_LPO: rst_req = ~lpo_lvl;
         default: rst_req = ~pin_n;
      endcase
   end

   // R9: low-leakage stop passes the pin straight through
   assert_lls_follow_R9: assert property (@(posedge clk) disable iff (!flt_rst_n)
      mode[1] |-> (rst_req == !pin_n));

   // R3: disabled or reserved run select passes the pin straight through
   assert_off_follow_R3: assert property (@(posedge clk) disable iff (!flt_rst_n)
      (mode == MODE_RUN && (rw_sel == RW_OFF || rw_sel == 2'b11)) |-> (rst_req == !pin_n));

   // R8: in stop mode bus ticks cannot raise a request from an idle pin level
   assert_stop_no_bus_R8: assert property (@(posedge clk) disable iff (!flt_rst_n)
      (mode == MODE_STOP && stop_sel && !lpo_tick && !rst_req) |=> (!rst_req || !pin_n));
endmodule

// File: tb/test_pin_reset_filter.sv
module test_pin_reset_filter;
   logic       clk = 1'b0;
   logic       por_n = 1'b0, warm_rst_n = 1'b1, pin_n = 1'b1;
   logic       bus_tick = 1'b1, lpo_tick = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0, rd_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       rst_req;
   int         n_chk = 0, n_fail = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   pin_reset_filter i_pin_reset_filter (
      .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .pin_n(pin_n),
      .bus_tick(bus_tick), .lpo_tick(lpo_tick), .mode(mode), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .rst_req(rst_req)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step(1);
      wr_en = 1'b0;
      step(1);
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
      rd_addr = a;
      #1;
      chk(req, rd_data, exp);
   endtask

   task automatic lpo_pulse(input int n);
      for (int i = 0; i < n; i++) begin
         lpo_tick = 1'b1;
         step(1);
         lpo_tick = 1'b0;
         step(2);
      end
   endtask

   task automatic t_reset;
      rd_chk("R1 ctrl", 3'd4, 8'h00);
      rd_chk("R1 width", 3'd5, 8'h00);
      chk("R1 rst_req", {7'd0, rst_req}, 8'h00);
   endtask

   task automatic t_regmap;
      wr(3'd4, 8'hFF);
      rd_chk("R2 ctrl mask", 3'd4, 8'h07);
      wr(3'd5, 8'hFF);
      rd_chk("R2 width mask", 3'd5, 8'h1F);
      rd_chk("R2 other offset", 3'd0, 8'h00);
      rd_chk("R2 offset 7", 3'd7, 8'h00);
      wr(3'd5, 8'h00);
   endtask

   task automatic t_bypass(input logic [7:0] ctrl);
      mode = 2'b00;
      wr(3'd4, ctrl);
      pin_n = 1'b0; #1;
      chk("R3 bypass assert", {7'd0, rst_req}, 8'h01);
      pin_n = 1'b1; #1;
      chk("R3 bypass release", {7'd0, rst_req}, 8'h00);
      step(1);
   endtask

   task automatic t_bus(input int w);
      mode = 2'b00;
      wr(3'd4, 8'h01);
      wr(3'd5, 8'(w));
      step(1);
      pin_n = 1'b0; #1;
      chk("R4 not yet", {7'd0, rst_req}, 8'h00);
      if (w > 0) begin
         repeat (w) @(posedge clk);
         #1;
         chk("R4 one short", {7'd0, rst_req}, 8'h00);
      end
      step(1);
      chk("R4 asserted", {7'd0, rst_req}, 8'h01);
      pin_n = 1'b1;
      if (w > 0) begin
         repeat (w) @(posedge clk);
         #1;
         chk("R4 release one short", {7'd0, rst_req}, 8'h01);
      end
      step(1);
      chk("R4 released", {7'd0, rst_req}, 8'h00);
   endtask

   task automatic t_glitch;
      mode = 2'b00;
      wr(3'd4, 8'h01);
      wr(3'd5, 8'd3);
      pin_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 pin_n = 1'b1;
      step(1);
      pin_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R5 restarted", {7'd0, rst_req}, 8'h00);
      step(1);
      chk("R5 full count", {7'd0, rst_req}, 8'h01);
      pin_n = 1'b1;
      step(5);
   endtask

   task automatic t_ticks;
      mode = 2'b00;
      wr(3'd4, 8'h01);
      wr(3'd5, 8'd0);
      bus_tick = 1'b0;
      pin_n = 1'b0;
      step(6);
      chk("R6 no tick no count", {7'd0, rst_req}, 8'h00);
      bus_tick = 1'b1;
      step(1);
      bus_tick = 1'b0;
      chk("R6 single tick", {7'd0, rst_req}, 8'h01);
      pin_n = 1'b1;
      bus_tick = 1'b1;
      step(2);
   endtask

   task automatic t_lpo;
      mode = 2'b00;
      wr(3'd4, 8'h02);
      pin_n = 1'b0;
      step(8);
      chk("R7 bus ticks ignored", {7'd0, rst_req}, 8'h00);
      lpo_pulse(2);
      chk("R7 two ticks", {7'd0, rst_req}, 8'h00);
      lpo_pulse(1);
      chk("R7 three ticks", {7'd0, rst_req}, 8'h01);
      pin_n = 1'b1;
      lpo_pulse(3);
      chk("R7 release", {7'd0, rst_req}, 8'h00);
   endtask

   task automatic t_stop;
      wr(3'd4, 8'h01);
      mode = 2'b01;
      step(1);
      pin_n = 1'b0; #1;
      chk("R8 stop sel 0 bypass", {7'd0, rst_req}, 8'h01);
      pin_n = 1'b1; #1;
      chk("R8 stop sel 0 release", {7'd0, rst_req}, 8'h00);
      wr(3'd4, 8'h05);
      pin_n = 1'b0;
      step(10);
      chk("R8 bus filter cleared", {7'd0, rst_req}, 8'h00);
      lpo_pulse(3);
      chk("R8 lpo filter in stop", {7'd0, rst_req}, 8'h01);
      pin_n = 1'b1;
      lpo_pulse(3);
      mode = 2'b00;
      step(1);
   endtask

   task automatic t_lls;
      wr(3'd4, 8'h06);
      mode = 2'b10;
      step(1);
      pin_n = 1'b0; #1;
      chk("R9 lls follows pin", {7'd0, rst_req}, 8'h01);
      pin_n = 1'b1; #1;
      chk("R9 lls release", {7'd0, rst_req}, 8'h00);
      mode = 2'b11;
      pin_n = 1'b0; #1;
      chk("R9 lls code 11", {7'd0, rst_req}, 8'h01);
      pin_n = 1'b1;
      mode = 2'b00;
      step(1);
   endtask

   task automatic t_resets;
      wr(3'd4, 8'h01);
      wr(3'd5, 8'h04);
      warm_rst_n = 1'b0;
      step(2);
      warm_rst_n = 1'b1;
      step(1);
      rd_chk("R10 warm keeps ctrl", 3'd4, 8'h01);
      rd_chk("R10 warm keeps width", 3'd5, 8'h04);
      por_n = 1'b0;
      step(2);
      por_n = 1'b1;
      step(1);
      rd_chk("R10 por clears ctrl", 3'd4, 8'h00);
      rd_chk("R10 por clears width", 3'd5, 8'h00);
   endtask

   initial begin
      step(3);
      por_n = 1'b1;
      step(2);
      t_reset();
      t_regmap();
      t_bypass(8'h00);
      t_bypass(8'h03);
      t_bus(0);
      t_bus(4);
      t_bus(31);
      t_glitch();
      t_ticks();
      t_lpo();
      t_stop();
      t_lls();
      t_resets();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule